// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a register-mapped watchdog for a system-on-chip. It keeps a down-counter that software loads from a reload register. Software keeps the system alive by writing a 16-bit key to a restart register. When the counter runs out, the block raises a one-cycle reset request and stops counting. A control register sets the enable bit, the tick source and the reset options. The counter either steps on every clock or steps only on the cycles where an external 1 MHz tick-enable input is high.

The control register follows a set rule. A write to it takes effect only when the write flips the enable bit. A rising enable loads the counter from the reload value and starts it. A falling enable freezes the counter. The reset-width register holds a pulse width for a separate pulse generator. It also holds two option bits, polarity and drive type. Each option bit is set or cleared only when the top byte of a write carries one of four key codes. An external input reports that the memory controller is held in reset. If this input is high at expiry, the block clears its control register and raises no request.

The bus carries 32-bit words. Writes are single-cycle strobes. Reads are combinational from the address. Misaligned addresses are ignored.

Top module: `wdk_top`

## Requirements
- R1: After reset, the count register (offset 0x00) and the reload register (0x04) both read 0x03EF1480. The control register (0x0C) reads 0, the reset-width register (0x18) reads 0x000000FF, and the mask register (0x1C) reads 0.
- R2: The reload register (0x04) and the mask register (0x1C) store whole 32-bit words. Writes to the count register (0x00) are ignored. Reads of 0x08, 0x10, 0x14 and of any unmapped or misaligned address return 0. A write whose address has either of its two low bits set changes nothing.
- R3: A write to 0x08 whose low 16 bits are 0x4755 copies the reload value into the counter. If enable is set, the counter also starts again. A write to 0x08 with any other value is ignored.
- R4: The control register keeps bits [5:0]: bit 0 enable, bit 1 system reset, bit 2 interrupt, bit 3 external signal, bit 4 1 MHz tick select, bit 5 full-chip mode. A control write is stored only when its bit 0 differs from the stored enable bit. Any other control write leaves the register unchanged.
- R5: A control write that sets enable from 0 to 1 loads the counter from the reload value and starts it. A control write that clears enable freezes the counter at its current value.
- R6: While the counter runs, it decrements by one on every clock when control bit 4 is 0. When bit 4 is 1, it decrements only on clocks where tick_1mhz is high.
- R7: On a tick where the running count is 1 or less, the count becomes 0 and counting stops. rst_req then goes high for exactly one cycle, in the cycle after that tick. Enable stays set.
- R8: If mem_in_reset is high on the expiring tick, the control register is cleared to 0, counting stops, and rst_req stays low.
- R9: A write to 0x18 replaces the pulse width in bits [19:0]. The top byte of the write then acts on bits 31 and 30: 0xA5 sets bit 31, 0x5A clears bit 31, 0xA8 sets bit 30, and 0x8A clears bit 30. Any other top byte leaves both bits as they were. Bits [29:20] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per asserted cycle |
| bus_addr | input | 5 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_1mhz | input | 1 | Tick enable used when control bit 4 is set |
| mem_in_reset | input | 1 | High while the memory controller is held in reset |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong counter state shows at the count register as soon as it is read, because the count reads back live. It also shows in the timing of rst_req: if the running flag or the decrement is wrong, the pulse comes early, comes late, or never comes. A control register that took a write it should have discarded shows in the very next read of offset 0x0C, and in whether the counter keeps running. Errors in the key-coded option bits stay hidden until the reset-width register is read. For this reason, every key-coded write is followed at once by a read.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   // byte offsets of the register words
   localparam logic [7:0] OFF_COUNT   = 8'h00;
   localparam logic [7:0] OFF_RELOAD  = 8'h04;
   localparam logic [7:0] OFF_RESTART = 8'h08;
   localparam logic [7:0] OFF_CTRL    = 8'h0C;
   localparam logic [7:0] OFF_WIDTH   = 8'h18;
   localparam logic [7:0] OFF_MASK    = 8'h1C;

   localparam logic [15:0] RESTART_KEY = 16'h4755;
   localparam int          CTRL_W      = 6;
   localparam int          CTRL_EN     = 0;
   localparam int          CTRL_SLOW   = 4;

   typedef enum logic [7:0] {
      OPT_POL_SET = 8'hA5,
      OPT_POL_CLR = 8'h5A,
      OPT_DRV_SET = 8'hA8,
      OPT_DRV_CLR = 8'h8A
   } opt_key_e;
endpackage

// File: rtl/wdk_counter.sv
module wdk_counter #(
   parameter int              CNT_W     = 32,
   parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             arm,
   input  logic             halt,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             tick,
   input  logic             mem_hold,
   output logic [CNT_W-1:0] count,
   output logic             clr_ctrl,
   output logic             rst_req
);
   logic running;
   logic fire;

   assign fire     = running && tick && !load && !halt && (count <= CNT_W'(1));
   assign clr_ctrl = fire && mem_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= CNT_INIT;
         running <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fire && !mem_hold;
         if (load || arm || halt) begin
            if (load) count <= reload_val;
            if (arm)  running <= 1'b1;
            if (halt) running <= 1'b0;
         end else if (fire) begin
            count   <= '0;
            running <= 1'b0;
         end else if (running && tick) begin
            count <= count - CNT_W'(1);
         end
      end
   end

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R7
   AST_STOPPED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (!running && count == '0)); // R7
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !load) |=> $stable(count)); // R5
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && !load && !halt && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1))); // R6
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
   import wdk_pkg::*;
#(
   parameter int               ADDR_W      = 5,
   parameter int               CNT_W       = 32,
   parameter int               PW_W        = 20,
   parameter logic [CNT_W-1:0] RELOAD_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [CNT_W-1:0] count_val,
   input  logic             clr_ctrl,
   output logic [CNT_W-1:0] reload_val,
   output logic             slow_tick_sel,
   output logic             load,
   output logic             arm,
   output logic             halt
);
   localparam int PAD_W = 30 - PW_W;

   initial begin
      assert (PW_W >= 8 && PW_W <= 30) else $error("PW_W out of range");
      assert (CNT_W >= 2 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (ADDR_W >= 5) else $error("ADDR_W too small for the map");
   end

   logic [CNT_W-1:0]  reload_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [PW_W-1:0]   pw_q;
   logic              pol_q, drv_q;
   logic [31:0]       mask_q;
   logic [31:0]       width_rd;

   logic aligned;
   logic sel_reload, sel_restart, sel_ctrl, sel_width, sel_mask;
   logic key_ok, ctrl_flip;
   opt_key_e opt;

   assign aligned     = (bus_addr[1:0] == 2'b00);
   assign sel_reload  = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_RELOAD));
   assign sel_restart = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_RESTART));
   assign sel_ctrl    = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_CTRL));
   assign sel_width   = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_WIDTH));
   assign sel_mask    = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_MASK));

   assign key_ok    = sel_restart && (bus_wdata[15:0] == RESTART_KEY);
   assign ctrl_flip = sel_ctrl && (bus_wdata[CTRL_EN] != ctrl_q[CTRL_EN]);
   assign load      = (ctrl_flip && bus_wdata[CTRL_EN]) || key_ok;
   assign arm       = (ctrl_flip && bus_wdata[CTRL_EN]) || (key_ok && ctrl_q[CTRL_EN]);
   assign halt      = ctrl_flip && !bus_wdata[CTRL_EN];
   assign opt       = opt_key_e'(bus_wdata[31:24]);

   assign reload_val    = reload_q;
   assign slow_tick_sel = ctrl_q[CTRL_SLOW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RELOAD_INIT;
         ctrl_q   <= '0;
         pw_q     <= PW_W'(8'hFF);
         pol_q    <= 1'b0;
         drv_q    <= 1'b0;
         mask_q   <= '0;
      end else begin
         if (sel_reload) reload_q <= bus_wdata[CNT_W-1:0];
         if (sel_mask)   mask_q   <= bus_wdata;
         if (ctrl_flip)     ctrl_q <= bus_wdata[CTRL_W-1:0];
         else if (clr_ctrl) ctrl_q <= '0;
         if (sel_width) begin
            pw_q <= bus_wdata[PW_W-1:0];
            case (opt)
               OPT_POL_SET: pol_q <= 1'b1;
               OPT_POL_CLR: pol_q <= 1'b0;
               OPT_DRV_SET: drv_q <= 1'b1;
               OPT_DRV_CLR: drv_q <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign width_rd = {pol_q, drv_q, {PAD_W{1'b0}}, pw_q};
      end else begin : g_nopad
         assign width_rd = {pol_q, drv_q, pw_q};
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         case (bus_addr)
            ADDR_W'(OFF_COUNT):  bus_rdata = 32'(count_val);
            ADDR_W'(OFF_RELOAD): bus_rdata = 32'(reload_q);
            ADDR_W'(OFF_CTRL):   bus_rdata = 32'(ctrl_q);
            ADDR_W'(OFF_WIDTH):  bus_rdata = width_rd;
            ADDR_W'(OFF_MASK):   bus_rdata = mask_q;
            default:             bus_rdata = '0;
         endcase
      end
   end

   AST_CTRL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ctrl && (bus_wdata[CTRL_EN] == ctrl_q[CTRL_EN]) && !clr_ctrl) |=> $stable(ctrl_q)); // R4
   AST_OPT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_width && !(bus_wdata[31:24] inside {8'hA5, 8'h5A, 8'hA8, 8'h8A})) |=> ($stable(pol_q) && $stable(drv_q))); // R9
   AST_NO_LOAD_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_restart && bus_wdata[15:0] != RESTART_KEY) |-> !load); // R3
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
   parameter int               ADDR_W      = 5,
   parameter int               CNT_W       = 32,
   parameter int               PW_W        = 20,
   parameter logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(32'h03EF1480)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick_1mhz,
   input  logic              mem_in_reset,
   output logic              rst_req
);
   logic [CNT_W-1:0] count_val, reload_val;
   logic slow_sel, load, arm, halt, clr_ctrl, tick;

   assign tick = slow_sel ? tick_1mhz : 1'b1;

   wdk_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PW_W(PW_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_val(count_val),
      .clr_ctrl(clr_ctrl), .reload_val(reload_val), .slow_tick_sel(slow_sel),
      .load(load), .arm(arm), .halt(halt));

   wdk_counter #(.CNT_W(CNT_W), .CNT_INIT(RELOAD_INIT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .arm(arm), .halt(halt),
      .reload_val(reload_val), .tick(tick), .mem_hold(mem_in_reset),
      .count(count_val), .clr_ctrl(clr_ctrl), .rst_req(rst_req));
endmodule

// File: tb/sim_wdk_top.sv
module sim_wdk_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  addr8 = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_1mhz = 1'b0;
   logic        mem_in_reset = 1'b0;
   logic        rst_req;
   int          n_chk = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   wdk_top u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(addr8[4:0]),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1mhz(tick_1mhz),
      .mem_in_reset(mem_in_reset), .rst_req(rst_req));

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h00, 32'h0, 32'h03EF1480, 4'd1},   // R1 count
      '{1'b0, 8'h04, 32'h0, 32'h03EF1480, 4'd1},   // R1 reload
      '{1'b0, 8'h0C, 32'h0, 32'h00000000, 4'd1},   // R1 control
      '{1'b0, 8'h18, 32'h0, 32'h000000FF, 4'd1},   // R1 width
      '{1'b0, 8'h1C, 32'h0, 32'h00000000, 4'd1},   // R1 mask
      '{1'b1, 8'h04, 32'h00000010, 32'h0, 4'd2},
      '{1'b0, 8'h04, 32'h0, 32'h00000010, 4'd2},   // R2 reload stored
      '{1'b1, 8'h00, 32'h00001234, 32'h0, 4'd2},
      '{1'b0, 8'h00, 32'h0, 32'h03EF1480, 4'd2},   // R2 count write ignored
      '{1'b1, 8'h08, 32'h00001111, 32'h0, 4'd3},
      '{1'b0, 8'h00, 32'h0, 32'h03EF1480, 4'd3},   // R3 wrong key
      '{1'b1, 8'h08, 32'hABCD4755, 32'h0, 4'd3},
      '{1'b0, 8'h00, 32'h0, 32'h00000010, 4'd3},   // R3 key loads count
      '{1'b1, 8'h1C, 32'hDEADBEEF, 32'h0, 4'd2},
      '{1'b0, 8'h1C, 32'h0, 32'hDEADBEEF, 4'd2},   // R2 mask stored
      '{1'b0, 8'h08, 32'h0, 32'h00000000, 4'd2},   // R2 restart reads 0
      '{1'b0, 8'h10, 32'h0, 32'h00000000, 4'd2},   // R2
      '{1'b0, 8'h14, 32'h0, 32'h00000000, 4'd2},   // R2
      '{1'b1, 8'h05, 32'h00000077, 32'h0, 4'd2},
      '{1'b0, 8'h04, 32'h0, 32'h00000010, 4'd2},   // R2 misaligned write
      '{1'b1, 8'h0C, 32'h0000003E, 32'h0, 4'd4},
      '{1'b0, 8'h0C, 32'h0, 32'h00000000, 4'd4},   // R4 no enable change
      '{1'b1, 8'h18, 32'hA5012345, 32'h0, 4'd9},
      '{1'b0, 8'h18, 32'h0, 32'h80012345, 4'd9},   // R9 polarity set
      '{1'b1, 8'h18, 32'hA8000007, 32'h0, 4'd9},
      '{1'b0, 8'h18, 32'h0, 32'hC0000007, 4'd9},   // R9 drive set
      '{1'b1, 8'h18, 32'h5A000009, 32'h0, 4'd9},
      '{1'b0, 8'h18, 32'h0, 32'h40000009, 4'd9},   // R9 polarity clear
      '{1'b1, 8'h18, 32'h1100000B, 32'h0, 4'd9},
      '{1'b0, 8'h18, 32'h0, 32'h4000000B, 4'd9}    // R9 unknown key byte
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; addr8 = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr8 = a;
      #1 d = bus_rdata;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v, v2;
      chk("R7 rst_req low in reset", {31'b0, rst_req}, 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
         else begin
            rd(VEC[i].addr, v);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
         end
      end
      wr(8'h18, 32'h8A00000A);
      rd(8'h18, v); chk("R9 drive clear", v, 32'h0000000A);

      // R5 / R6: fast tick counting from reload 0x10
      wr(8'h0C, 32'h1);
      rd(8'h00, v); chk("R5 enable loads count", v, 32'h10);
      repeat (3) @(negedge clk);
      rd(8'h00, v); chk("R6 decrement per clock", v, 32'h0D);
      wr(8'h0C, 32'h3);
      rd(8'h0C, v); chk("R4 same-enable write discarded", v, 32'h1);
      wr(8'h0C, 32'h0);
      rd(8'h00, v);
      repeat (5) @(negedge clk);
      rd(8'h00, v2); chk("R5 disable freezes count", v2, v);

      // R6: slow tick
      wr(8'h0C, 32'h11);
      rd(8'h0C, v); chk("R4 control stored on enable flip", v, 32'h11);
      repeat (4) @(negedge clk);
      rd(8'h00, v); chk("R6 no tick no decrement", v, 32'h10);
      for (int k = 0; k < 3; k++) begin
         tick_1mhz = 1'b1; @(negedge clk); tick_1mhz = 1'b0; @(negedge clk);
      end
      rd(8'h00, v); chk("R6 three ticks", v, 32'h0D);
      wr(8'h0C, 32'h0);

      // R7: expiry from reload 3
      wr(8'h04, 32'h3);
      wr(8'h0C, 32'h1);
      chk("R7 no request at start", {31'b0, rst_req}, 32'h0);
      @(negedge clk); rd(8'h00, v); chk("R7 count 2", v, 32'h2);
      @(negedge clk); chk("R7 not yet", {31'b0, rst_req}, 32'h0);
      @(negedge clk); rd(8'h00, v); chk("R7 count zero", v, 32'h0);
      chk("R7 request high", {31'b0, rst_req}, 32'h1);
      @(negedge clk); chk("R7 request one cycle", {31'b0, rst_req}, 32'h0);
      repeat (3) @(negedge clk);
      rd(8'h00, v); chk("R7 stopped at zero", v, 32'h0);
      rd(8'h0C, v); chk("R7 enable kept", v, 32'h1);

      // R3: key restarts while enabled
      wr(8'h08, 32'h00004755);
      rd(8'h00, v); chk("R3 restart loads", v, 32'h3);
      @(negedge clk); rd(8'h00, v); chk("R3 restart runs", v, 32'h2);
      repeat (4) @(negedge clk);

      // R8: memory controller held in reset at expiry
      wr(8'h0C, 32'h0);
      mem_in_reset = 1'b1;
      wr(8'h0C, 32'h3);
      v2 = 32'h0;
      repeat (6) begin
         @(negedge clk);
         if (rst_req) v2 = 32'h1;
      end
      chk("R8 no request", v2, 32'h0);
      rd(8'h0C, v); chk("R8 control cleared", v, 32'h0);
      rd(8'h00, v); chk("R8 count zero", v, 32'h0);
      mem_in_reset = 1'b0;

      finish_run();
   end
endmodule